// File: doc/BRIEF.md
# Privilege Mode and Stack-Pointer Selector

This block keeps the supervisor and master bits of a 16-bit processor status register, together with the rest of that register. From them it derives the privilege level of the core. It decides which of three stack pointers (user, interrupt, master) answers a reference to address register 7. It also drives the three function-code lines that classify each bus cycle. The master bit never changes privilege. It only chooses between the two supervisor stacks, and an interrupt exception returns the core to the interrupt stack.

Four kinds of instruction may change the register: a move to it, and an AND, OR or XOR of an immediate value into it. A return from exception also changes it, by reloading a value taken from the stack frame. All five are legal only at supervisor level. At user level, these five and the STOP/RESET class raise a privilege violation and have no effect. Exception entry presents the old register value for stacking and forces supervisor level. Each accepted register change produces a one-cycle pipeline-flush request.

Top module: `priv_mode_ctl`

## Requirements
- R1: After reset the status register reads 16'h2000 (supervisor bit at position 13 set, master bit at position 12 clear). Stack select reads 2'b01 and flush and violation are low.
- R2: Stack select encodes 2'b00 user, 2'b01 interrupt and 2'b10 master. It reads user when the supervisor bit is 0. Otherwise it reads master or interrupt as the master bit is 1 or 0. While `exc_active` is high the supervisor stack chosen by the master bit is used whatever the supervisor bit holds.
- R3: The status register changes only on the clock edge after an accepted register write, an accepted return, or an exception entry.
- R4: A register write applies `sr_wr_data` to all 16 bits according to `sr_wr_op`: 2'b00 replaces, 2'b01 ANDs, 2'b10 ORs and 2'b11 XORs. The result is visible after the next clock edge.
- R5: An accepted return loads the whole register from `rte_sr` at the next edge. If a write and a return arrive together, the return wins.
- R6: With the supervisor bit clear, a register write, a return or `priv_insn` drives `priv_viol` high in the same cycle. The register is left unchanged and no flush follows.
- R7: With the supervisor bit set, `priv_viol` stays low for either value of the master bit.
- R8: `flush` is high for exactly the one cycle after each clock edge that accepted a register write or return, and is low otherwise.
- R9: Exception entry copies the register as it stood before entry into `saved_sr`. At the same edge it sets the supervisor bit and leaves the other bits, apart from the master bit, unchanged.
- R10: Entry with `exc_is_irq` high clears the master bit. Entry with it low keeps the master bit.
- R11: `fc` is {supervisor bit OR `exc_active`, 2'b10 when `bus_prog` is high else 2'b01}. This gives 001 user data, 010 user program, 101 supervisor data and 110 supervisor program.
- R12: An exception entry in the same cycle as a write or return takes priority. The write or return is dropped with no flush and no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr_valid | input | 1 | A status-register write instruction completes this cycle |
| sr_wr_op | input | 2 | Write kind: replace, AND, OR, XOR |
| sr_wr_data | input | 16 | Immediate or source operand of the write |
| rte_valid | input | 1 | A return-from-exception completes this cycle |
| rte_sr | input | 16 | Register value read from the stack frame |
| exc_enter | input | 1 | Exception entry strobe |
| exc_is_irq | input | 1 | The entering exception is an interrupt |
| exc_active | input | 1 | Exception processing in progress |
| priv_insn | input | 1 | A STOP/RESET class instruction is presented |
| bus_prog | input | 1 | Current bus cycle is a program fetch |
| cur_sr | output | 16 | Current status register |
| saved_sr | output | 16 | Register value captured at the last exception entry |
| sp_sel | output | 2 | Active stack-pointer select |
| fc | output | 3 | Function code for the bus cycle |
| priv_viol | output | 1 | Privilege violation |
| flush | output | 1 | Pipeline-flush request |

## Verification
The hardest state to reach is supervisor bit clear with master bit set. No instruction at user level can build it, because any write there is refused. The stimulus first takes an exception to regain supervisor level and then issues a return whose frame value is 16'h1000. This makes it possible to show that the user stack is selected, that raising `exc_active` moves the select to the master stack, and that a later interrupt entry clears the master bit. The same-cycle collision of exception entry with a register write is also driven directly.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int SR_W = 16;

  typedef enum logic [1:0] {
    SR_MOVE = 2'b00,
    SR_AND  = 2'b01,
    SR_OR   = 2'b10,
    SR_EOR  = 2'b11
  } sr_op_e;

  typedef enum logic [1:0] {
    SP_USER   = 2'b00,
    SP_INTR   = 2'b01,
    SP_MASTER = 2'b10
  } sp_sel_e;

  // Result of one status-register instruction on the full register.
  function automatic logic [SR_W-1:0] sr_apply(input sr_op_e op,
                                               input logic [SR_W-1:0] cur,
                                               input logic [SR_W-1:0] imm);
    logic [SR_W-1:0] r;
    unique case (op)
      SR_MOVE: r = imm;
      SR_AND:  r = cur & imm;
      SR_OR:   r = cur | imm;
      default: r = cur ^ imm;
    endcase
    return r;
  endfunction

  function automatic sp_sel_e pick_stack(input logic sup, input logic master);
    if (!sup)        return SP_USER;
    else if (master) return SP_MASTER;
    else             return SP_INTR;
  endfunction

  function automatic logic [2:0] fc_encode(input logic sup, input logic prog);
    return {sup, prog ? 2'b10 : 2'b01};
  endfunction
endpackage

// File: rtl/priv_access_gate.sv
module priv_access_gate (
  input  logic s_bit,
  input  logic exc_enter,
  input  logic wr_req,
  input  logic rte_req,
  input  logic priv_insn,
  output logic wr_ok,
  output logic rte_ok,
  output logic viol
);
  logic allowed;

  assign allowed = s_bit & ~exc_enter;
  assign wr_ok   = wr_req  & allowed;
  assign rte_ok  = rte_req & allowed;
  assign viol    = ~s_bit & ~exc_enter & (wr_req | rte_req | priv_insn);
endmodule

// File: rtl/priv_sr_reg.sv
module priv_sr_reg
  import priv_pkg::*;
#(
  parameter int S_BIT = 13,
  parameter int M_BIT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  sr_op_e          wr_op,
  input  logic [SR_W-1:0] wr_data,
  input  logic            rte_ok,
  input  logic [SR_W-1:0] rte_val,
  input  logic            exc_enter,
  input  logic            exc_is_irq,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] saved_q,
  output logic            flush_q
);
  localparam logic [SR_W-1:0] RST_SR = SR_W'(1) << S_BIT;

  logic [SR_W-1:0] sr_d;
  logic [SR_W-1:0] exc_sr;

  always_comb begin
    exc_sr        = sr_q;
    exc_sr[S_BIT] = 1'b1;
    if (exc_is_irq) exc_sr[M_BIT] = 1'b0;
  end

  always_comb begin
    if (exc_enter)   sr_d = exc_sr;
    else if (rte_ok) sr_d = rte_val;
    else if (wr_ok)  sr_d = sr_apply(wr_op, sr_q, wr_data);
    else             sr_d = sr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= RST_SR;
      saved_q <= '0;
      flush_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      flush_q <= wr_ok | rte_ok;
      if (exc_enter) saved_q <= sr_q;
    end
  end
endmodule

// File: rtl/priv_bus_map.sv
module priv_bus_map
  import priv_pkg::*;
(
  input  logic       s_bit,
  input  logic       m_bit,
  input  logic       exc_active,
  input  logic       bus_prog,
  output logic [1:0] sp_sel,
  output logic [2:0] fc
);
  logic sup;

  assign sup    = s_bit | exc_active;
  assign sp_sel = pick_stack(sup, m_bit);
  assign fc     = fc_encode(sup, bus_prog);
endmodule

// File: rtl/priv_mode_ctl.sv
module priv_mode_ctl
  import priv_pkg::*;
#(
  parameter int S_BIT = 13,
  parameter int M_BIT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sr_wr_valid,
  input  logic [1:0]  sr_wr_op,
  input  logic [15:0] sr_wr_data,
  input  logic        rte_valid,
  input  logic [15:0] rte_sr,
  input  logic        exc_enter,
  input  logic        exc_is_irq,
  input  logic        exc_active,
  input  logic        priv_insn,
  input  logic        bus_prog,
  output logic [15:0] cur_sr,
  output logic [15:0] saved_sr,
  output logic [1:0]  sp_sel,
  output logic [2:0]  fc,
  output logic        priv_viol,
  output logic        flush
);
  logic wr_ok;
  logic rte_ok;

  priv_access_gate u_gate (
    .s_bit     (cur_sr[S_BIT]),
    .exc_enter (exc_enter),
    .wr_req    (sr_wr_valid),
    .rte_req   (rte_valid),
    .priv_insn (priv_insn),
    .wr_ok     (wr_ok),
    .rte_ok    (rte_ok),
    .viol      (priv_viol)
  );

  priv_sr_reg #(.S_BIT(S_BIT), .M_BIT(M_BIT)) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .wr_op      (sr_op_e'(sr_wr_op)),
    .wr_data    (sr_wr_data),
    .rte_ok     (rte_ok),
    .rte_val    (rte_sr),
    .exc_enter  (exc_enter),
    .exc_is_irq (exc_is_irq),
    .sr_q       (cur_sr),
    .saved_q    (saved_sr),
    .flush_q    (flush)
  );

  priv_bus_map u_map (
    .s_bit      (cur_sr[S_BIT]),
    .m_bit      (cur_sr[M_BIT]),
    .exc_active (exc_active),
    .bus_prog   (bus_prog),
    .sp_sel     (sp_sel),
    .fc         (fc)
  );
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk #(
  parameter int S_BIT = 13,
  parameter int M_BIT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_enter,
  input logic        exc_is_irq,
  input logic        exc_active,
  input logic [15:0] cur_sr,
  input logic [15:0] saved_sr,
  input logic [1:0]  sp_sel,
  input logic [2:0]  fc,
  input logic        priv_viol,
  input logic        flush,
  input logic        wr_ok,
  input logic        rte_ok
);
  AST_STABLE_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_enter && !wr_ok && !rte_ok) |=> $stable(cur_sr)); // R3
  AST_VIOL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |=> ($stable(cur_sr) && !flush)); // R6
  AST_SUPER_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sr[S_BIT] |-> !priv_viol); // R7
  AST_FLUSH_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok || rte_ok) |=> flush); // R8
  AST_FLUSH_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok || rte_ok) |=> !flush); // R8
  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (saved_sr == $past(cur_sr) && cur_sr[S_BIT])); // R9
  AST_IRQ_CLEARS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && exc_is_irq) |=> !cur_sr[M_BIT]); // R10
  AST_TRAP_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && !exc_is_irq) |=> (cur_sr[M_BIT] == $past(cur_sr[M_BIT]))); // R10
  AST_EXC_FC_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    exc_active |-> (fc[2] && sp_sel != 2'b00)); // R11
  AST_USER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_sr[S_BIT] && !exc_active) |-> (sp_sel == 2'b00 && !fc[2])); // R2
endmodule

bind priv_mode_ctl priv_mode_chk #(.S_BIT(S_BIT), .M_BIT(M_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_enter  (exc_enter),
  .exc_is_irq (exc_is_irq),
  .exc_active (exc_active),
  .cur_sr     (cur_sr),
  .saved_sr   (saved_sr),
  .sp_sel     (sp_sel),
  .fc         (fc),
  .priv_viol  (priv_viol),
  .flush      (flush),
  .wr_ok      (wr_ok),
  .rte_ok     (rte_ok)
);

// File: tb/tb_priv_mode_ctl.sv
module tb_priv_mode_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_wr_valid = 1'b0;
  logic [1:0]  sr_wr_op = 2'b00;
  logic [15:0] sr_wr_data = '0;
  logic        rte_valid = 1'b0;
  logic [15:0] rte_sr = '0;
  logic        exc_enter = 1'b0;
  logic        exc_is_irq = 1'b0;
  logic        exc_active = 1'b0;
  logic        priv_insn = 1'b0;
  logic        bus_prog = 1'b0;
  logic [15:0] cur_sr;
  logic [15:0] saved_sr;
  logic [1:0]  sp_sel;
  logic [2:0]  fc;
  logic        priv_viol;
  logic        flush;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  priv_mode_ctl dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sr_wr_valid = 0; rte_valid = 0; exc_enter = 0; exc_is_irq = 0;
    exc_active = 0; priv_insn = 0; bus_prog = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic sr_write(input logic [1:0] op, input logic [15:0] d);
    sr_wr_valid = 1; sr_wr_op = op; sr_wr_data = d;
    tick();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    tick(); tick();
    rst_n = 1;
    #1;
    check("R1 sr", cur_sr, 16'h2000);
    check("R1 sp", sp_sel, 2'b01);
    check("R1 flush/viol", {flush, priv_viol}, 2'b00);
    check("R11 fc super data", fc, 3'b101);
  endtask

  task automatic t_sr_ops();
    sr_write(2'b10, 16'h1000);
    check("R4 or", cur_sr, 16'h3000);
    check("R8 flush high", flush, 1'b1);
    check("R2 master", sp_sel, 2'b10);
    tick();
    check("R8 flush one cycle", flush, 1'b0);
    check("R3 stable", cur_sr, 16'h3000);
    priv_insn = 1; #1;
    check("R7 master no viol", priv_viol, 1'b0);
    idle();
    sr_write(2'b01, 16'hEFFF);
    check("R4 and", cur_sr, 16'h2000);
    check("R2 interrupt", sp_sel, 2'b01);
    priv_insn = 1; #1;
    check("R7 intr no viol", priv_viol, 1'b0);
    idle();
    sr_write(2'b11, 16'h00FF);
    check("R4 eor", cur_sr, 16'h20FF);
    sr_write(2'b00, 16'h0003);
    check("R4 move", cur_sr, 16'h0003);
    check("R2 user", sp_sel, 2'b00);
    bus_prog = 1; #1;
    check("R11 user prog", fc, 3'b010);
    bus_prog = 0; #1;
    check("R11 user data", fc, 3'b001);
  endtask

  task automatic t_user_viol();
    sr_wr_valid = 1; sr_wr_op = 2'b00; sr_wr_data = 16'h2000; #1;
    check("R6 viol on write", priv_viol, 1'b1);
    tick(); idle();
    check("R6 sr kept", cur_sr, 16'h0003);
    check("R6 no flush", flush, 1'b0);
    rte_valid = 1; rte_sr = 16'h2700; #1;
    check("R6 viol on rte", priv_viol, 1'b1);
    tick(); idle();
    check("R6 rte ignored", cur_sr, 16'h0003);
    priv_insn = 1; #1;
    check("R6 viol on stop", priv_viol, 1'b1);
    idle(); #1;
    check("R6 viol clears", priv_viol, 1'b0);
  endtask

  task automatic t_exception();
    exc_enter = 1; exc_is_irq = 0; exc_active = 1; #1;
    check("R2 exc forces supervisor stack", sp_sel, 2'b01);
    check("R11 exc fc", fc, 3'b101);
    tick(); idle();
    check("R9 saved", saved_sr, 16'h0003);
    check("R9 sr", cur_sr, 16'h2003);
    sr_write(2'b00, 16'h3700);
    exc_enter = 1; exc_is_irq = 1;
    tick(); idle();
    check("R9 saved irq", saved_sr, 16'h3700);
    check("R10 irq clears M", cur_sr, 16'h2700);
    sr_write(2'b00, 16'h3000);
    exc_enter = 1; exc_is_irq = 0;
    tick(); idle();
    check("R10 trap keeps M", cur_sr, 16'h3000);
    check("R3 no flush on entry", flush, 1'b0);
  endtask

  task automatic t_rte_user_master();
    rte_valid = 1; rte_sr = 16'h1000;
    sr_wr_valid = 1; sr_wr_op = 2'b00; sr_wr_data = 16'h2222;
    tick(); idle();
    check("R5 rte wins", cur_sr, 16'h1000);
    check("R8 rte flush", flush, 1'b1);
    check("R2 user with M set", sp_sel, 2'b00);
    exc_active = 1; #1;
    check("R2 exc uses master", sp_sel, 2'b10);
    exc_enter = 1; exc_is_irq = 1;
    tick(); idle();
    check("R10 irq from user", cur_sr, 16'h2000);
    check("R9 saved user", saved_sr, 16'h1000);
  endtask

  task automatic t_priority();
    sr_wr_valid = 1; sr_wr_op = 2'b00; sr_wr_data = 16'h0000;
    exc_enter = 1; exc_is_irq = 0; #1;
    check("R12 no viol", priv_viol, 1'b0);
    tick(); idle();
    check("R12 entry wins", cur_sr, 16'h2000);
    check("R12 no flush", flush, 1'b0);
  endtask

  initial begin
    t_reset();
    t_sr_ops();
    t_user_viol();
    t_exception();
    t_rte_user_master();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule